// File: doc/BRIEF.md
# Time-of-Day Register Front End

This block is the 32-bit register face of a time-of-day counter. A host reaches it over a simple single-cycle bus: an address, a write enable with write data, a read enable, and a registered read-data word. The block does no timekeeping arithmetic. It sits between the bus and the counter, which provides the live seconds, nanoseconds and remaining fine-adjust count. The block drives the counter's load strobe, its rate configuration and its fine-adjust start.

The 48-bit seconds value spans two words, and nanoseconds take a third word. Multi-word coherence needs no lock bit and works in both directions:
- A read of the nanoseconds word returns the live nanoseconds and freezes the live seconds in a snapshot. Later reads of the two seconds words return that snapshot.
- Writes to the two seconds words are only held in a staging register. A write of the nanoseconds word then loads the staged seconds and the new nanoseconds into the counter in one strobe.

The bus has no back-pressure: every access completes in the cycle it is presented. The read data follows one cycle later and holds until the next read.

Top module: `tod_reg_frontend`

## Requirements
- R1: After reset, `rdata_o`, `load_o`, `adj_start_o` and all configuration outputs are zero.
- R2: A read of byte address 0x038 returns the clock-frequency constant given by parameter `FREQ_VAL`. Writes to it are ignored.
- R3: A read of the nanoseconds word (0x108) returns the live nanoseconds and captures the live seconds. Reads of 0x104 (seconds bits 31:0) and 0x100 return the captured value until the next nanoseconds read, even if the live seconds change.
- R4: Word 0x100 carries seconds bits 47:32 in its bits 15:0. Its bits 31:16 read as zero, and written bits 31:16 are discarded.
- R5: Writes to 0x100 and 0x104 only stage seconds. They do not assert `load_o`.
- R6: A write to 0x108 asserts `load_o` for exactly one cycle, in the cycle after the write. In that cycle, `load_sec_o` holds the staged seconds and `load_ns_o` holds the written data.
- R7: The period (0x110) and adjust period (0x114) hold 20 bits. The drift amount (0x11C) and drift rate (0x120) hold 16 bits. Each drives its output and reads back, with unused upper bits reading zero and ignored on write.
- R8: A write to the adjust count (0x118) asserts `adj_start_o` for one cycle, in the cycle after the write, with `adj_count_o` equal to write data bits 19:0. A read of 0x118 returns the live `adj_remain_i`, zero-extended.
- R9: Reads of unmapped addresses return zero. Writes to unmapped addresses change no register and raise no strobe.
- R10: Read data appears in the cycle after `rd_en_i` and holds while no read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| live_sec_i | input | 48 | Live seconds from the counter |
| live_ns_i | input | 32 | Live nanoseconds from the counter |
| adj_remain_i | input | 20 | Live remaining fine-adjust count |
| load_o | output | 1 | One-cycle time load strobe |
| load_sec_o | output | 48 | Seconds to load |
| load_ns_o | output | 32 | Nanoseconds to load |
| period_o | output | 20 | Per-cycle increment, fixed point |
| adj_period_o | output | 20 | Increment used while adjusting |
| adj_start_o | output | 1 | One-cycle fine-adjust start |
| adj_count_o | output | 20 | Fine-adjust cycle count |
| drift_o | output | 16 | Drift correction amount |
| drift_rate_o | output | 16 | Cycles between drift corrections |

## Verification
Every result comes from one register stage:
- Read data, the load strobe and the adjust-start strobe become valid one clock edge after the access that causes them.
- Configuration outputs change at that same edge.
- The snapshot is taken at the edge that ends the nanoseconds read.

The bench drives each access between edges and lets one rising edge pass. It then samples on the following falling edge, where the registered result must already be present. Single-cycle strobes are sampled again one edge later, where they must be low. The snapshot checks change the live seconds only after that capture edge, so a stale value cannot match by accident.

// File: rtl/tod_regs_pkg.sv
package tod_regs_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_FREQ    = 12'h038;
  localparam logic [ADDR_W-1:0] A_SEC_HI  = 12'h100;
  localparam logic [ADDR_W-1:0] A_SEC_LO  = 12'h104;
  localparam logic [ADDR_W-1:0] A_NSEC    = 12'h108;
  localparam logic [ADDR_W-1:0] A_PERIOD  = 12'h110;
  localparam logic [ADDR_W-1:0] A_ADJ_PER = 12'h114;
  localparam logic [ADDR_W-1:0] A_ADJ_CNT = 12'h118;
  localparam logic [ADDR_W-1:0] A_DRIFT   = 12'h11C;
  localparam logic [ADDR_W-1:0] A_DRATE   = 12'h120;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_FREQ, SEL_SEC_HI, SEL_SEC_LO, SEL_NSEC,
    SEL_PERIOD, SEL_ADJ_PER, SEL_ADJ_CNT, SEL_DRIFT, SEL_DRATE
  } reg_sel_e;
endpackage

// File: rtl/tod_addr_dec.sv
module tod_addr_dec
  import tod_regs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    unique case (addr_i)
      A_FREQ:    sel_o = SEL_FREQ;
      A_SEC_HI:  sel_o = SEL_SEC_HI;
      A_SEC_LO:  sel_o = SEL_SEC_LO;
      A_NSEC:    sel_o = SEL_NSEC;
      A_PERIOD:  sel_o = SEL_PERIOD;
      A_ADJ_PER: sel_o = SEL_ADJ_PER;
      A_ADJ_CNT: sel_o = SEL_ADJ_CNT;
      A_DRIFT:   sel_o = SEL_DRIFT;
      A_DRATE:   sel_o = SEL_DRATE;
      default:   sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/tod_time_regs.sv
module tod_time_regs #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 32,
  localparam int LO_W = 32,
  localparam int HI_W = SEC_W - LO_W
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             rd_ns_i,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic             wr_ns_i,
  input  logic [31:0]      wdata_i,
  input  logic [SEC_W-1:0] live_sec_i,
  output logic [SEC_W-1:0] snap_sec_o,
  output logic             load_o,
  output logic [SEC_W-1:0] load_sec_o,
  output logic [NS_W-1:0]  load_ns_o
);
  logic [HI_W-1:0] stage_hi_q;
  logic [LO_W-1:0] stage_lo_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      snap_sec_o <= '0;
      stage_hi_q <= '0;
      stage_lo_q <= '0;
      load_o     <= 1'b0;
      load_sec_o <= '0;
      load_ns_o  <= '0;
    end else begin
      if (rd_ns_i) snap_sec_o <= live_sec_i;
      if (wr_hi_i) stage_hi_q <= wdata_i[HI_W-1:0];
      if (wr_lo_i) stage_lo_q <= wdata_i[LO_W-1:0];
      load_o <= wr_ns_i;
      if (wr_ns_i) begin
        load_sec_o <= {stage_hi_q, stage_lo_q};
        load_ns_o  <= wdata_i[NS_W-1:0];
      end
    end
  end

  // R3: the snapshot moves only on a nanoseconds read
  p_snap_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !rd_ns_i |=> $stable(snap_sec_o));
  // R5: seconds writes alone never load the counter
  p_stage_no_load_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((wr_hi_i || wr_lo_i) && !wr_ns_i) |=> !load_o);
  // R6: each load strobe follows a nanoseconds write
  p_load_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    load_o |-> $past(wr_ns_i));
endmodule

// File: rtl/tod_cfg_regs.sv
module tod_cfg_regs #(
  parameter int PER_W   = 20,
  parameter int CNT_W   = 20,
  parameter int DRIFT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               wr_per_i,
  input  logic               wr_adj_per_i,
  input  logic               wr_cnt_i,
  input  logic               wr_drift_i,
  input  logic               wr_rate_i,
  input  logic [31:0]        wdata_i,
  output logic [PER_W-1:0]   period_o,
  output logic [PER_W-1:0]   adj_period_o,
  output logic               adj_start_o,
  output logic [CNT_W-1:0]   adj_count_o,
  output logic [DRIFT_W-1:0] drift_o,
  output logic [DRIFT_W-1:0] drift_rate_o
);
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      period_o     <= '0;
      adj_period_o <= '0;
      adj_start_o  <= 1'b0;
      adj_count_o  <= '0;
      drift_o      <= '0;
      drift_rate_o <= '0;
    end else begin
      if (wr_per_i)     period_o     <= wdata_i[PER_W-1:0];
      if (wr_adj_per_i) adj_period_o <= wdata_i[PER_W-1:0];
      if (wr_drift_i)   drift_o      <= wdata_i[DRIFT_W-1:0];
      if (wr_rate_i)    drift_rate_o <= wdata_i[DRIFT_W-1:0];
      adj_start_o <= wr_cnt_i;
      if (wr_cnt_i)     adj_count_o  <= wdata_i[CNT_W-1:0];
    end
  end

  // R8: a start strobe is always caused by a count write
  p_start_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    adj_start_o |-> $past(wr_cnt_i));
  // R7: period holds when not written
  p_period_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !wr_per_i |=> $stable(period_o));
endmodule

// File: rtl/tod_reg_frontend.sv
module tod_reg_frontend
  import tod_regs_pkg::*;
#(
  parameter int          SEC_W    = 48,
  parameter int          NS_W     = 32,
  parameter int          PER_W    = 20,
  parameter int          CNT_W    = 20,
  parameter int          DRIFT_W  = 16,
  parameter logic [31:0] FREQ_VAL = 32'd156250000
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic [11:0]        addr_i,
  input  logic               wr_en_i,
  input  logic [31:0]        wdata_i,
  input  logic               rd_en_i,
  output logic [31:0]        rdata_o,
  input  logic [SEC_W-1:0]   live_sec_i,
  input  logic [NS_W-1:0]    live_ns_i,
  input  logic [CNT_W-1:0]   adj_remain_i,
  output logic               load_o,
  output logic [SEC_W-1:0]   load_sec_o,
  output logic [NS_W-1:0]    load_ns_o,
  output logic [PER_W-1:0]   period_o,
  output logic [PER_W-1:0]   adj_period_o,
  output logic               adj_start_o,
  output logic [CNT_W-1:0]   adj_count_o,
  output logic [DRIFT_W-1:0] drift_o,
  output logic [DRIFT_W-1:0] drift_rate_o
);
  localparam int HI_W = SEC_W - 32;

  reg_sel_e          sel;
  logic [SEC_W-1:0]  snap_sec;
  logic [DATA_W-1:0] rd_mux;

  tod_addr_dec u_dec (.addr_i(addr_i), .sel_o(sel));

  tod_time_regs #(.SEC_W(SEC_W), .NS_W(NS_W)) u_time (
    .clk_i(clk_i), .rst_n_i(rst_n_i),
    .rd_ns_i(rd_en_i && sel == SEL_NSEC),
    .wr_hi_i(wr_en_i && sel == SEL_SEC_HI),
    .wr_lo_i(wr_en_i && sel == SEL_SEC_LO),
    .wr_ns_i(wr_en_i && sel == SEL_NSEC),
    .wdata_i(wdata_i), .live_sec_i(live_sec_i), .snap_sec_o(snap_sec),
    .load_o(load_o), .load_sec_o(load_sec_o), .load_ns_o(load_ns_o)
  );

  tod_cfg_regs #(.PER_W(PER_W), .CNT_W(CNT_W), .DRIFT_W(DRIFT_W)) u_cfg (
    .clk_i(clk_i), .rst_n_i(rst_n_i),
    .wr_per_i(wr_en_i && sel == SEL_PERIOD),
    .wr_adj_per_i(wr_en_i && sel == SEL_ADJ_PER),
    .wr_cnt_i(wr_en_i && sel == SEL_ADJ_CNT),
    .wr_drift_i(wr_en_i && sel == SEL_DRIFT),
    .wr_rate_i(wr_en_i && sel == SEL_DRATE),
    .wdata_i(wdata_i),
    .period_o(period_o), .adj_period_o(adj_period_o),
    .adj_start_o(adj_start_o), .adj_count_o(adj_count_o),
    .drift_o(drift_o), .drift_rate_o(drift_rate_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_FREQ:    rd_mux = FREQ_VAL;
      SEL_SEC_HI:  rd_mux[HI_W-1:0]    = snap_sec[SEC_W-1:32];
      SEL_SEC_LO:  rd_mux              = snap_sec[31:0];
      SEL_NSEC:    rd_mux[NS_W-1:0]    = live_ns_i;
      SEL_PERIOD:  rd_mux[PER_W-1:0]   = period_o;
      SEL_ADJ_PER: rd_mux[PER_W-1:0]   = adj_period_o;
      SEL_ADJ_CNT: rd_mux[CNT_W-1:0]   = adj_remain_i;
      SEL_DRIFT:   rd_mux[DRIFT_W-1:0] = drift_o;
      SEL_DRATE:   rd_mux[DRIFT_W-1:0] = drift_rate_o;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  // R9: unmapped reads return zero
  p_unmapped_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rd_en_i && sel == SEL_NONE) |=> rdata_o == '0);
  // R4: upper half of the seconds-high word is zero
  p_hi_width_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rd_en_i && addr_i == A_SEC_HI) |=> rdata_o[31:16] == 16'h0);
  // R10: read data holds between reads
  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !rd_en_i |=> $stable(rdata_o));
  // R2: frequency read returns the constant
  p_freq_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rd_en_i && addr_i == A_FREQ) |=> rdata_o == FREQ_VAL);
endmodule

// File: tb/tb_tod_reg_frontend.sv
module tb_tod_reg_frontend;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] FREQ = 32'd156250000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic [47:0] live_sec = '0, load_sec;
  logic [31:0] live_ns = '0, load_ns;
  logic [19:0] adj_remain = '0, period, adj_period, adj_count;
  logic        load, adj_start;
  logic [15:0] drift, drift_rate;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_reg_frontend #(.FREQ_VAL(FREQ)) dut (
    .clk_i(clk), .rst_n_i(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata),
    .live_sec_i(live_sec), .live_ns_i(live_ns), .adj_remain_i(adj_remain),
    .load_o(load), .load_sec_o(load_sec), .load_ns_o(load_ns),
    .period_o(period), .adj_period_o(adj_period), .adj_start_o(adj_start),
    .adj_count_o(adj_count), .drift_o(drift), .drift_rate_o(drift_rate)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // drive at falling edge, return at next falling edge (one rising edge passed)
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    chk("R1 rdata", rdata, 0);
    chk("R1 load", load, 0);
    chk("R1 adj_start", adj_start, 0);
    chk("R1 period", period, 0);
    chk("R1 drift_rate", drift_rate, 0);
  endtask

  task automatic t_freq();
    logic [31:0] d;
    bus_read(12'h038, d); chk("R2 freq read", d, FREQ);
    bus_write(12'h038, 32'h1);
    bus_read(12'h038, d); chk("R2 freq write ignored", d, FREQ);
  endtask

  task automatic t_snapshot();
    logic [31:0] d;
    live_sec = 48'h1234_89AB_CDEF; live_ns = 32'd500;
    bus_read(12'h108, d); chk("R3 ns live", d, 500);
    live_sec = 48'hFFFF_0000_0001; live_ns = 32'd7;
    bus_read(12'h104, d); chk("R3 sec lo snapshot", d, 32'h89AB_CDEF);
    bus_read(12'h100, d); chk("R4 sec hi snapshot", d, 32'h0000_1234);
    bus_read(12'h108, d); chk("R3 ns second read", d, 7);
    bus_read(12'h104, d); chk("R3 sec lo new snapshot", d, 32'h1);
    bus_read(12'h100, d); chk("R4 sec hi zero-extended", d, 32'h0000_FFFF);
  endtask

  task automatic t_commit();
    bus_write(12'h100, 32'hABCD_5678); chk("R5 no load after hi", load, 0);
    bus_write(12'h104, 32'h1111_1111); chk("R5 no load after lo", load, 0);
    bus_write(12'h108, 32'd999);
    chk("R6 load strobe", load, 1);
    chk("R6 load sec", load_sec, 48'h5678_1111_1111);
    chk("R6 load ns", load_ns, 999);
    @(negedge clk); chk("R6 strobe one cycle", load, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    bus_write(12'h110, 32'hFFF1_2345); chk("R7 period out", period, 20'h12345);
    bus_read(12'h110, d);              chk("R7 period read", d, 32'h0001_2345);
    bus_write(12'h114, 32'hFFFA_BCDE); chk("R7 adj period out", adj_period, 20'hABCDE);
    bus_write(12'h11C, 32'hABCD_1234); chk("R7 drift out", drift, 16'h1234);
    bus_read(12'h11C, d);              chk("R7 drift read", d, 32'h0000_1234);
    bus_write(12'h120, 32'h5555_0042); bus_read(12'h120, d);
    chk("R7 rate read", d, 32'h42);
  endtask

  task automatic t_adjust();
    logic [31:0] d;
    bus_write(12'h118, 32'h00F0_00FF);
    chk("R8 start strobe", adj_start, 1);
    chk("R8 count value", adj_count, 20'h000FF);
    @(negedge clk); chk("R8 start one cycle", adj_start, 0);
    adj_remain = 20'd42;
    bus_read(12'h118, d); chk("R8 live remaining", d, 42);
    adj_remain = 20'd0;
    bus_read(12'h118, d); chk("R8 complete zero", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_read(12'h10C, d); chk("R9 unmapped read", d, 0);
    bus_write(12'h10C, 32'hFFFF_FFFF);
    chk("R9 no load", load, 0);
    chk("R9 no start", adj_start, 0);
    bus_read(12'h110, d); chk("R9 period intact", d, 32'h0001_2345);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    live_ns = 32'd77;
    addr = 12'h108; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
    chk("R10 data after one edge", rdata, 77);
    live_ns = 32'd88;
    @(negedge clk); @(negedge clk);
    chk("R10 data held", rdata, 77);
    bus_read(12'h108, d); chk("R10 next read", d, 88);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_freq();
    t_snapshot();
    t_commit();
    t_cfg();
    t_adjust();
    t_unmapped();
    t_latency();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule